// File: doc/BRIEF.md
# Prioritized Edge Interrupt Controller

This controller gathers sixteen edge-triggered interrupt sources and one bypass input, and presents one interrupt at a time to a processor core as a 6-bit priority code with a one-cycle valid strobe. Each source has a programmable 3-bit level. A source is forwarded only when its level is strictly above a single global mask value. The bypass input skips the level and mask logic and always yields the top code.

Software sees a small register bank through a word-select, byte-enable port. The bank holds a pending-status word in which 0 means pending, a mask word, and four packed level words. Each source stays pending in the status word until software writes its bit back to 1. The core learns that an input went inactive through a code of zero.

Top module: `prio_edge_irq`

## Requirements
- R1: After reset the status word reads 0x0000FFFF, the mask word and all four level words read 0, and ipValid and ipCode are 0.
- R2: The register select picks the status word at 0, the mask at 1 and the level words at 4, 5, 6 and 7, which hold sources 0-3, 4-7, 8-11 and 12-15. Selects 2 and 3 read 0, and writes to them change no register.
- R3: A write replaces only the bytes whose enable bit is set. Byte lane b is bits 8b+7..8b, and the other lanes keep their values.
- R4: A rising edge on srcIn[s] clears status bit s to 0 whatever its level. The bit stays 0 until software writes it back. The status and output update on the second clock edge after the input changes.
- R5: The level of source s is bits 8*(s%4)+2..8*(s%4) of level word s/4. A rising edge on s gives ipValid=1 and ipCode=16+s only when that level, taken as an unsigned number, is strictly greater than the full 32-bit mask word. An equal level is not forwarded.
- R6: When several qualifying rising edges arrive in the same cycle, the lowest-numbered source wins the code, and every rising source still clears its status bit.
- R7: A rising edge on bypassIn gives ipCode=32 regardless of mask, levels and status. It takes precedence over all source edges in the same cycle.
- R8: A falling edge on any source or on bypassIn gives ipValid=1 with ipCode=0, unless a bypass edge or a qualifying source edge occurs in the same cycle.
- R9: ipValid is high for exactly one cycle per event. ipCode holds its value until the next event.
- R10: An input held high produces a single event. No further event follows until it falls and rises again.
- R11: When a status write and a source edge hit the same clock edge, the source's bit ends at 0. The other written bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srcIn | input | 16 | Interrupt source inputs, index = source number |
| bypassIn | input | 1 | Bypass interrupt input, always code 32 |
| regWordSel | input | 3 | Register word select |
| regWrEn | input | 1 | Write strobe |
| regByteEn | input | 4 | Per-lane write enables |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected word (combinational) |
| ipCode | output | 6 | Priority code: 16+s, 32 or 0 |
| ipValid | output | 1 | One-cycle strobe for a new ipCode |

## Verification
The bench aims at the sharp edges of the level comparison. A level equal to the mask must stay silent; a design using >= would emit a code there. A mask word above 7 must silence every source; a design comparing only the low three bits would not. Simultaneous edges on several sources, and a bypass edge arriving together with a source edge, reveal a reversed priority encoder or a missing bypass precedence. A status write landing on the same edge as a source event shows whether the event or the write wins, and a held-high input shows whether the design detects levels rather than edges.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_SRC       = 16;
  localparam int SRC_IDX_W     = $clog2(NUM_SRC);
  localparam int DATA_W        = 32;
  localparam int BYTES         = DATA_W / 8;
  localparam int LVL_W         = 3;
  localparam int SRC_PER_WORD  = BYTES;
  localparam int LVL_WORDS     = NUM_SRC / SRC_PER_WORD;
  localparam int SEL_W         = 3;
  localparam int CODE_W        = 6;
  localparam int STATUS_SEL    = 0;
  localparam int MASK_SEL      = 1;
  localparam int LVL_WORD_BASE = 4;
  localparam int SRC_CODE_BASE = 16;
  localparam int BYPASS_CODE   = 32;

  typedef struct packed {
    logic                 fire;
    logic                 bypass;
    logic                 clear;
    logic [SRC_IDX_W-1:0] srcIdx;
    logic [NUM_SRC-1:0]   riseVec;
  } irqStrobe_t;
endpackage

// File: rtl/irq_edge_arb.sv
module irq_edge_arb
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               bypassIn,
  input  logic [NUM_SRC-1:0] passVec,
  output irqStrobe_t         strobe
);
  logic [NUM_SRC-1:0]   srcS1, srcS2, riseVec, fallVec, qualVec;
  logic                 bypS1, bypS2, bypRise, anyFall, found;
  logic [SRC_IDX_W-1:0] winIdx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcS1 <= '0;
      srcS2 <= '0;
      bypS1 <= 1'b0;
      bypS2 <= 1'b0;
    end else begin
      srcS2 <= srcS1;
      srcS1 <= srcIn;
      bypS2 <= bypS1;
      bypS1 <= bypassIn;
    end
  end

  always_comb begin
    riseVec = srcS1 & ~srcS2;
    fallVec = ~srcS1 & srcS2;
    qualVec = riseVec & passVec;
    bypRise = bypS1 & ~bypS2;
    anyFall = (|fallVec) | (~bypS1 & bypS2);
    found   = 1'b0;
    winIdx  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (qualVec[i]) begin
        found  = 1'b1;
        winIdx = SRC_IDX_W'(i);
      end
    end
    strobe.riseVec = riseVec;
    strobe.srcIdx  = winIdx;
    strobe.bypass  = bypRise;
    strobe.clear   = !bypRise && !found && anyFall;
    strobe.fire    = bypRise || found || anyFall;
  end

  // R10
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && !strobe.bypass && !strobe.clear) |=> !strobe.riseVec[$past(strobe.srcIdx)]);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  irqStrobe_t         strobe,
  input  logic [SEL_W-1:0]   regWordSel,
  input  logic               regWrEn,
  input  logic [BYTES-1:0]   regByteEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [NUM_SRC-1:0] passVec,
  output logic [CODE_W-1:0]  ipCode,
  output logic               ipValid
);
  localparam logic [DATA_W-1:0] STATUS_RST = {{(DATA_W-NUM_SRC){1'b0}}, {NUM_SRC{1'b1}}};

  logic [DATA_W-1:0] statusReg, maskReg, statusMerged;
  logic [DATA_W-1:0] lvlWord [LVL_WORDS];

  function automatic logic [DATA_W-1:0] laneMerge(input logic [DATA_W-1:0] oldVal,
                                                  input logic [DATA_W-1:0] newVal,
                                                  input logic [BYTES-1:0] be);
    logic [DATA_W-1:0] res;
    res = oldVal;
    for (int b = 0; b < BYTES; b++)
      if (be[b]) res[b*8 +: 8] = newVal[b*8 +: 8];
    return res;
  endfunction

  always_comb begin
    statusMerged = statusReg;
    if (regWrEn && regWordSel == SEL_W'(STATUS_SEL))
      statusMerged = laneMerge(statusReg, regWrData, regByteEn);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusReg <= STATUS_RST;
      maskReg   <= '0;
    end else begin
      statusReg <= statusMerged & ~{{(DATA_W-NUM_SRC){1'b0}}, strobe.riseVec};
      if (regWrEn && regWordSel == SEL_W'(MASK_SEL))
        maskReg <= laneMerge(maskReg, regWrData, regByteEn);
    end
  end

  for (genvar w = 0; w < LVL_WORDS; w++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n)
        lvlWord[w] <= '0;
      else if (regWrEn && regWordSel == SEL_W'(LVL_WORD_BASE + w))
        lvlWord[w] <= laneMerge(lvlWord[w], regWrData, regByteEn);
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_pass
    assign passVec[s] =
      DATA_W'(lvlWord[s / SRC_PER_WORD][(s % SRC_PER_WORD) * 8 +: LVL_W]) > maskReg;
  end

  always_comb begin
    regRdData = '0;
    if (regWordSel == SEL_W'(STATUS_SEL)) regRdData = statusReg;
    if (regWordSel == SEL_W'(MASK_SEL))   regRdData = maskReg;
    for (int w = 0; w < LVL_WORDS; w++)
      if (regWordSel == SEL_W'(LVL_WORD_BASE + w)) regRdData = lvlWord[w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipValid <= 1'b0;
      ipCode  <= '0;
    end else begin
      ipValid <= strobe.fire;
      if (strobe.fire) begin
        if (strobe.bypass)     ipCode <= CODE_W'(BYPASS_CODE);
        else if (strobe.clear) ipCode <= '0;
        else                   ipCode <= CODE_W'(SRC_CODE_BASE) + CODE_W'(strobe.srcIdx);
      end
    end
  end

  // R4
  status_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ipValid && ipCode[5:4] == 2'b01) |-> !statusReg[ipCode[3:0]]);

  // R5
  pass_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ipValid && ipCode[5:4] == 2'b01) |-> ((($past(passVec)) >> ipCode[3:0]) & 16'd1) != 16'd0);

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ipValid |-> $stable(ipCode));
endmodule

// File: rtl/prio_edge_irq.sv
module prio_edge_irq
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               bypassIn,
  input  logic [SEL_W-1:0]   regWordSel,
  input  logic               regWrEn,
  input  logic [BYTES-1:0]   regByteEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [CODE_W-1:0]  ipCode,
  output logic               ipValid
);
  irqStrobe_t         strobe;
  logic [NUM_SRC-1:0] passVec;

  irq_edge_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .srcIn    (srcIn),
    .bypassIn (bypassIn),
    .passVec  (passVec),
    .strobe   (strobe)
  );

  irq_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .regWordSel (regWordSel),
    .regWrEn    (regWrEn),
    .regByteEn  (regByteEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .passVec    (passVec),
    .ipCode     (ipCode),
    .ipValid    (ipValid)
  );
endmodule

// File: tb/prio_edge_irq_bench.sv
module prio_edge_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] srcIn = '0;
  logic        bypassIn = 1'b0;
  logic [2:0]  regWordSel = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [5:0]  ipCode;
  logic        ipValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  prio_edge_irq u_prio_edge_irq (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .bypassIn(bypassIn),
    .regWordSel(regWordSel), .regWrEn(regWrEn), .regByteEn(regByteEn),
    .regWrData(regWrData), .regRdData(regRdData), .ipCode(ipCode), .ipValid(ipValid)
  );

  // behavioural reference model
  logic [31:0] mIsr, mImr;
  logic [31:0] mIlr [4];
  logic [15:0] mS1, mS2;
  logic        mB1, mB2, mValid, mFall;
  logic [5:0]  mCode;
  int          mWin, mLvl;

  function automatic logic [31:0] mRead(input logic [2:0] sel);
    case (sel)
      3'd0: return mIsr;
      3'd1: return mImr;
      3'd4, 3'd5, 3'd6, 3'd7: return mIlr[sel - 3'd4];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mIsr = 32'h0000FFFF; mImr = 0;
      for (int w = 0; w < 4; w++) mIlr[w] = 0;
      mS1 = 0; mS2 = 0; mB1 = 0; mB2 = 0; mValid = 0; mCode = 0;
    end else begin
      mWin = -1;
      for (int s = 0; s < 16; s++) begin
        mLvl = int'((mIlr[s/4] >> ((s%4)*8)) & 32'd7);
        if (mS1[s] && !mS2[s] && mWin < 0 && 32'(mLvl) > mImr) mWin = s;
      end
      mFall = (|(~mS1 & mS2)) || (!mB1 && mB2);
      if (regWrEn) begin
        for (int b = 0; b < 4; b++) begin
          if (regByteEn[b]) begin
            case (regWordSel)
              3'd0: mIsr[b*8 +: 8] = regWrData[b*8 +: 8];
              3'd1: mImr[b*8 +: 8] = regWrData[b*8 +: 8];
              3'd4, 3'd5, 3'd6, 3'd7: mIlr[regWordSel - 3'd4][b*8 +: 8] = regWrData[b*8 +: 8];
              default: ;
            endcase
          end
        end
      end
      mIsr = mIsr & ~{16'd0, mS1 & ~mS2};
      mValid = 0;
      if (mB1 && !mB2) begin mValid = 1; mCode = 6'd32; end
      else if (mWin >= 0) begin mValid = 1; mCode = 6'(16 + mWin); end
      else if (mFall) begin mValid = 1; mCode = 6'd0; end
      mS2 = mS1; mS1 = srcIn; mB2 = mB1; mB1 = bypassIn;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk("R9 valid vs model", {31'd0, ipValid}, {31'd0, mValid});
      chk("R5/R7/R8 code vs model", {26'd0, ipCode}, {26'd0, mCode});
      chk("R2/R4 read vs model", regRdData, mRead(regWordSel));
    end
  end

  task automatic wrReg(input logic [2:0] sel, input logic [31:0] data, input logic [3:0] be);
    regWordSel = sel; regWrData = data; regByteEn = be; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = '0;
  endtask

  task automatic rdChk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
    regWordSel = sel;
    #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic outChk(input string tag, input logic v, input logic [5:0] c);
    chk(tag, {26'd0, ipCode, v}, {26'd0, c, v ? 1'b1 : 1'b0});
    chk(tag, {31'd0, ipValid}, {31'd0, v});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    // R1 reset state
    rdChk("R1 status", 3'd0, 32'h0000FFFF);
    rdChk("R1 mask", 3'd1, 32'd0);
    for (int w = 4; w < 8; w++) rdChk("R1 level", 3'(w), 32'd0);
    outChk("R1 outputs", 1'b0, 6'd0);
    step(1);
    // R2 map and unused selects
    wrReg(3'd1, 32'h00000003, 4'hF);
    wrReg(3'd2, 32'hDEADBEEF, 4'hF);
    wrReg(3'd3, 32'hCAFEF00D, 4'hF);
    wrReg(3'd4, 32'h01020304, 4'hF);
    rdChk("R2 hole 2", 3'd2, 32'd0);
    rdChk("R2 hole 3", 3'd3, 32'd0);
    rdChk("R2 mask", 3'd1, 32'd3);
    rdChk("R2 level0", 3'd4, 32'h01020304);
    rdChk("R2 status untouched", 3'd0, 32'h0000FFFF);
    step(1);
    // R3 byte lanes
    wrReg(3'd5, 32'h11223344, 4'hF);
    wrReg(3'd5, 32'hAAAAAAAA, 4'b0100);
    rdChk("R3 lane merge", 3'd5, 32'h11AA3344);
    step(1);
    // levels: src4=2 (== mask), src5=5; mask=2
    wrReg(3'd4, 32'd0, 4'hF);
    wrReg(3'd5, 32'h00000502, 4'hF);
    wrReg(3'd1, 32'h00000002, 4'hF);
    srcIn[5] = 1'b1;
    step(2);
    outChk("R5 forward src5", 1'b1, 6'd21);
    step(1);
    outChk("R9 hold code", 1'b0, 6'd21);
    rdChk("R4 status bit5", 3'd0, 32'h0000FFDF);
    step(1);
    srcIn[4] = 1'b1;
    step(2);
    outChk("R5 equal level blocked", 1'b0, 6'd21);
    rdChk("R4 status bit4 regardless", 3'd0, 32'h0000FFCF);
    step(3);
    outChk("R10 held high no event", 1'b0, 6'd21);
    srcIn[4] = 1'b0;
    step(2);
    outChk("R8 fall clears", 1'b1, 6'd0);
    step(1);
    srcIn[5] = 1'b0;
    step(2);
    outChk("R8 second fall", 1'b1, 6'd0);
    step(1);
    // R6 simultaneous edges: src8=1 (<mask), src9=6, src10=7
    wrReg(3'd0, 32'h0000FFFF, 4'hF);
    wrReg(3'd6, 32'h00070601, 4'hF);
    srcIn[10:8] = 3'b111;
    step(2);
    outChk("R6 lowest qualifying wins", 1'b1, 6'd25);
    rdChk("R6 all rising update status", 3'd0, 32'h0000F8FF);
    step(1);
    srcIn[10:8] = 3'b000;
    step(3);
    // R7 bypass beats source
    bypassIn = 1'b1; srcIn[9] = 1'b1;
    step(2);
    outChk("R7 bypass wins", 1'b1, 6'd32);
    step(1);
    // R5 wide mask silences all
    wrReg(3'd1, 32'h00000100, 4'hF);
    srcIn[10] = 1'b1;
    step(2);
    outChk("R5 wide mask blocks", 1'b0, 6'd32);
    step(1);
    // R11 status write on same edge as event
    wrReg(3'd0, 32'h0000F8FF, 4'hF);
    srcIn[3] = 1'b1;
    step(1);
    wrReg(3'd0, 32'h0000FFFF, 4'hF);
    rdChk("R11 event beats write", 3'd0, 32'h0000FFF7);
    step(1);
    // randomized phase, model compared every cycle
    for (int k = 0; k < 4000; k++) begin
      srcIn    = srcIn ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      bypassIn = (($urandom % 16) == 0) ? ~bypassIn : bypassIn;
      regWordSel = 3'($urandom);
      if (($urandom % 8) == 0) begin
        regWrData = ($urandom % 2) ? 32'($urandom % 8) : 32'($urandom);
        regByteEn = 4'($urandom);
        regWrEn   = 1'b1;
      end else begin
        regWrEn = 1'b0;
      end
      @(negedge clk);
    end
    regWrEn = 1'b0;
    step(3);
    finishRun();
  end
endmodule